// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block turns a set of twelve interrupt request flags into one vector request for an 8051-class processor core. Every source has an enable bit and a two-bit priority level. The level is built from a low-priority register bit and a high-priority register bit. A master enable masks all sources at once. On each machine-cycle strobe the block takes in the pending flags and picks a winner in that same cycle. It raises a vector request only when all of these hold:

- the core reports the final cycle of an instruction;
- that instruction is not a return-from-interrupt;
- that instruction does not write an enable or priority register;
- no handler of equal or higher level is already running.

The block keeps one in-service bit per level. A taken vector sets the bit for the winning level. A return-from-interrupt clears the highest set bit, so up to four handlers can nest. Together with the vector, the block sends a one-cycle clear pulse back to the sources whose flags are cleared by hardware: the timer sources, and the external pin sources when they run in edge mode. All other flags stay set until software clears them in the peripheral.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While and right after reset, `req_o` is 0, `hwclr_o` is all zeros and `insvc_o` is all zeros.
- R2: A source whose `en_i` bit is 0 is never vectored. When `ea_i` is 0, no source is vectored.
- R3: The level of source i is `{prio_hi_i[i], prio_lo_i[i]}`, where 3 is the highest level and 0 the lowest. Among eligible sources, the one with the highest level wins.
- R4: Among eligible sources at the same level, the lowest source index wins.
- R5: A vector is taken only at a clock edge where `mc_tick_i` and `last_cyc_i` are both 1. `req_o` is then high for exactly the one clock cycle after that edge.
- R6: No vector is taken at an edge where `is_reti_i` or `wr_ctrl_i` is 1.
- R7: A source is vectored only if its level is strictly above the highest level set in `insvc_o`. A higher level preempts a running handler. An equal or lower level waits.
- R8: A taken vector sets bit L of `insvc_o`, where L is the winner's level. An edge with `mc_tick_i`, `last_cyc_i` and `is_reti_i` all 1 clears the highest set bit of `insvc_o`. With no bit set, this has no effect.
- R9: `hwclr_o` is a one-hot pulse at the winner's bit position, in the same cycle as `req_o`. It fires only for sources in the timer mask (default bits 1 and 3). It also fires for sources in the external mask (default bits 0 and 2) whose `edge_mode_i` bit is 1. For every other source it stays 0.
- R10: While `req_o` is 1, `idx_o` holds the winner's index and `vec_addr_o` equals 3 + 8 × `idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick_i | input | 1 | Machine-cycle strobe |
| last_cyc_i | input | 1 | Core is on the final cycle of an instruction |
| is_reti_i | input | 1 | Current instruction is a return-from-interrupt |
| wr_ctrl_i | input | 1 | Current instruction writes an enable or priority register |
| flag_i | input | 12 | Interrupt request flags, one per source |
| en_i | input | 12 | Per-source enable bits |
| ea_i | input | 1 | Master enable |
| prio_lo_i | input | 12 | Low bit of each source's level |
| prio_hi_i | input | 12 | High bit of each source's level |
| edge_mode_i | input | 12 | Edge mode selection, meaningful for external sources |
| req_o | output | 1 | Vector request strobe |
| idx_o | output | 4 | Index of the winning source |
| vec_addr_o | output | 16 | Handler address of the winning source |
| hwclr_o | output | 12 | Hardware clear pulse back to the sources |
| insvc_o | output | 4 | In-service bit per level |

## Verification
All results are registered once. `req_o`, `idx_o`, `vec_addr_o`, `hwclr_o` and the updated `insvc_o` appear in the clock cycle after the rising edge at which `mc_tick_i` was high. Nothing is visible earlier, and `req_o` is gone again one cycle later. The bench sets up the inputs on a falling edge and raises the strobe for exactly one rising edge. It drops the strobe at the next falling edge and samples every output there, halfway through the cycle in which the result is due. A separate check one cycle later confirms that the request is a single-cycle pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 2;
  localparam int N_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] plo_i,
  input  logic [N_SRC-1:0] phi_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o,
  output lvl_t             win_lvl_o
);
  logic [N_LVL-1:0]            lvl_any;
  logic [N_LVL-1:0][IDX_W-1:0] lvl_idx;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    logic [N_SRC-1:0] hit;
    logic [IDX_W-1:0] first;
    always_comb begin
      hit = '0;
      for (int i = 0; i < N_SRC; i++)
        hit[i] = pend_i[i] && ({phi_i[i], plo_i[i]} == lvl_t'(g));
    end
    always_comb begin
      first = '0;
      for (int i = N_SRC-1; i >= 0; i--)
        if (hit[i]) first = IDX_W'(i);
    end
    assign lvl_any[g] = |hit;
    assign lvl_idx[g] = first;
  end

  always_comb begin
    win_vld_o = |lvl_any;
    win_lvl_o = '0;
    win_idx_o = lvl_idx[0];
    for (int l = 0; l < N_LVL; l++) begin
      if (lvl_any[l]) begin
        win_lvl_o = lvl_t'(l);
        win_idx_o = lvl_idx[l];
      end
    end
  end

  // R3 / R4: no pending source outranks the chosen winner
  always_comb begin
    if (win_vld_o) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (pend_i[i]) begin
          assert_lvl_order_R3: assert ({phi_i[i], plo_i[i]} <= win_lvl_o);
          assert_idx_order_R4: assert (({phi_i[i], plo_i[i]} != win_lvl_o) ||
                                       (IDX_W'(i) >= win_idx_o));
        end
      end
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  lvl_t             push_lvl_i,
  input  logic             pop_i,
  output logic [N_LVL-1:0] isr_o,
  output logic             top_any_o,
  output lvl_t             top_lvl_o
);
  logic [N_LVL-1:0] isr_q, isr_d;

  always_comb begin
    top_any_o = |isr_q;
    top_lvl_o = '0;
    for (int l = 0; l < N_LVL; l++)
      if (isr_q[l]) top_lvl_o = lvl_t'(l);
  end

  always_comb begin
    isr_d = isr_q;
    if (pop_i && top_any_o) isr_d[top_lvl_o] = 1'b0;
    if (push_i)             isr_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else if (push_i || pop_i) isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  assert_push_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> isr_q[$past(push_lvl_i)]);
  assert_pop_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && (|isr_q)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
  assert_no_push_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int               N_SRC    = 12,
  parameter int               ADDR_W   = 16,
  parameter logic [N_SRC-1:0] TMR_MASK = 12'h00A,
  parameter logic [N_SRC-1:0] EXT_MASK = 12'h005,
  localparam int              IDX_W    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick_i,
  input  logic              last_cyc_i,
  input  logic              is_reti_i,
  input  logic              wr_ctrl_i,
  input  logic [N_SRC-1:0]  flag_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              ea_i,
  input  logic [N_SRC-1:0]  prio_lo_i,
  input  logic [N_SRC-1:0]  prio_hi_i,
  input  logic [N_SRC-1:0]  edge_mode_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [N_SRC-1:0]  hwclr_o,
  output logic [N_LVL-1:0]  insvc_o
);
  logic [N_SRC-1:0] pend;
  logic             win_vld, top_any, poll_ok, fire, pop;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, top_lvl;

  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [N_SRC-1:0] clr_q, clr_d;

  assign pend = flag_i & en_i & {N_SRC{ea_i}};

  irq_prio_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .pend_i(pend), .plo_i(prio_lo_i), .phi_i(prio_hi_i),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign poll_ok = mc_tick_i && last_cyc_i && !is_reti_i && !wr_ctrl_i;
  assign fire    = poll_ok && win_vld && (!top_any || (win_lvl > top_lvl));
  assign pop     = mc_tick_i && last_cyc_i && is_reti_i;

  irq_isr_stack u_isr (
    .clk(clk), .rst_n(rst_n),
    .push_i(fire), .push_lvl_i(win_lvl), .pop_i(pop),
    .isr_o(insvc_o), .top_any_o(top_any), .top_lvl_o(top_lvl)
  );

  always_comb begin
    req_d = fire;
    idx_d = idx_q;
    clr_d = '0;
    if (fire) begin
      idx_d = win_idx;
      clr_d = (N_SRC'(1) << win_idx) & (TMR_MASK | (EXT_MASK & edge_mode_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
      clr_q <= '0;
    end else begin
      req_q <= req_d;
      clr_q <= clr_d;
      if (fire) idx_q <= idx_d;
    end
  end

  assign req_o      = req_q;
  assign idx_o      = idx_q;
  assign hwclr_o    = clr_q;
  assign vec_addr_o = {{(ADDR_W-IDX_W-3){1'b0}}, idx_q, 3'b011};

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(mc_tick_i && last_cyc_i));
  assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(!is_reti_i && !wr_ctrl_i));
  assert_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(ea_i));
  assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hwclr_o) && ((hwclr_o & ~(TMR_MASK | EXT_MASK)) == '0));
  assert_clr_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hwclr_o) |-> req_o);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int NV = 15;

  typedef struct packed {
    logic [11:0] flg, en;
    logic        ea;
    logic [11:0] plo, phi;
    logic        last, reti, wr, ereq;
    logic [3:0]  eidx;
    logic [11:0] eclr;
  } row_t;

  localparam logic [68:0] TBL [NV] = '{
    {12'h001,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd0, 12'h001}, // R9 ext edge
    {12'h004,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd2, 12'h000}, // R9 ext level
    {12'h002,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd1, 12'h002}, // R9 timer
    {12'h800,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd11,12'h000}, // R10
    {12'h030,12'hFFF,1'b1,12'h020,12'h000,1'b1,1'b0,1'b0,1'b1,4'd5, 12'h000}, // R3
    {12'h030,12'hFFF,1'b1,12'h000,12'h010,1'b1,1'b0,1'b0,1'b1,4'd4, 12'h000}, // R3
    {12'h300,12'hFFF,1'b1,12'h200,12'h200,1'b1,1'b0,1'b0,1'b1,4'd9, 12'h000}, // R3
    {12'h006,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd1, 12'h002}, // R4
    {12'h009,12'hFFE,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b1,4'd3, 12'h008}, // R2 R4
    {12'h001,12'hFFE,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b0,4'd0, 12'h000}, // R2
    {12'h001,12'hFFF,1'b0,12'h000,12'h000,1'b1,1'b0,1'b0,1'b0,4'd0, 12'h000}, // R2
    {12'h001,12'hFFF,1'b1,12'h000,12'h000,1'b0,1'b0,1'b0,1'b0,4'd0, 12'h000}, // R5
    {12'h001,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b1,1'b0,1'b0,4'd0, 12'h000}, // R6
    {12'h001,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b1,1'b0,4'd0, 12'h000}, // R6
    {12'h000,12'hFFF,1'b1,12'h000,12'h000,1'b1,1'b0,1'b0,1'b0,4'd0, 12'h000}  // R2
  };

  logic clk = 1'b0;
  logic rst_n;
  logic mc_tick, last_cyc, is_reti, wr_ctrl, ea;
  logic [11:0] flag, en, plo, phi, edge_mode;
  logic req;
  logic [3:0] idx;
  logic [15:0] vaddr;
  logic [11:0] hwclr;
  logic [3:0] insvc;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mc_tick_i(mc_tick), .last_cyc_i(last_cyc),
    .is_reti_i(is_reti), .wr_ctrl_i(wr_ctrl), .flag_i(flag), .en_i(en),
    .ea_i(ea), .prio_lo_i(plo), .prio_hi_i(phi), .edge_mode_i(edge_mode),
    .req_o(req), .idx_o(idx), .vec_addr_o(vaddr), .hwclr_o(hwclr),
    .insvc_o(insvc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mc_tick = 0; last_cyc = 0; is_reti = 0; wr_ctrl = 0;
    flag = '0; en = '1; ea = 1; plo = '0; phi = '0; edge_mode = 12'h001;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one strobe edge, then sample at the following falling edge
  task automatic poll(input logic [11:0] f, input logic lc, input logic rt,
                      input logic tk);
    flag = f; last_cyc = lc; is_reti = rt; mc_tick = tk;
    @(negedge clk);
    mc_tick = 0; flag = '0;
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 req", {31'b0, req}, 0);
    chk("R1 hwclr", {20'b0, hwclr}, 0);
    chk("R1 insvc", {28'b0, insvc}, 0);

    for (int k = 0; k < NV; k++) begin
      row_t v;
      v = row_t'(TBL[k]);
      do_reset();
      en = v.en; ea = v.ea; plo = v.plo; phi = v.phi; wr_ctrl = v.wr;
      poll(v.flg, v.last, v.reti, 1'b1);
      wr_ctrl = 0;
      chk($sformatf("R5 row%0d req", k), {31'b0, req}, {31'b0, v.ereq});
      chk($sformatf("R9 row%0d hwclr", k), {20'b0, hwclr}, {20'b0, v.eclr});
      if (v.ereq) begin
        chk($sformatf("R10 row%0d idx", k), {28'b0, idx}, {28'b0, v.eidx});
        chk($sformatf("R10 row%0d addr", k), {16'b0, vaddr}, 32'd3 + 32'd8 * v.eidx);
        chk($sformatf("R8 row%0d insvc", k), {28'b0, insvc},
            32'd1 << {v.phi[v.eidx], v.plo[v.eidx]});
      end else begin
        chk($sformatf("R8 row%0d insvc", k), {28'b0, insvc}, 0);
      end
    end

    // nesting: src5,6 at level 1, src7 at level 2, src0 at level 0
    do_reset();
    plo = 12'h060; phi = 12'h080;
    poll(12'h020, 1, 0, 1);
    chk("R7 nest first req", {31'b0, req}, 1);
    chk("R8 nest insvc lvl1", {28'b0, insvc}, 4'b0010);
    @(negedge clk);
    chk("R5 single pulse", {31'b0, req}, 0);
    poll(12'h040, 1, 0, 1);
    chk("R7 equal level blocked", {31'b0, req}, 0);
    poll(12'h001, 1, 0, 1);
    chk("R7 lower level blocked", {31'b0, req}, 0);
    poll(12'h080, 1, 0, 1);
    chk("R7 preempt req", {31'b0, req}, 1);
    chk("R7 preempt idx", {28'b0, idx}, 7);
    chk("R8 insvc two levels", {28'b0, insvc}, 4'b0110);
    poll(12'h000, 1, 1, 1);
    chk("R8 reti pops top", {28'b0, insvc}, 4'b0010);
    poll(12'h000, 1, 1, 1);
    chk("R8 reti pops last", {28'b0, insvc}, 4'b0000);
    poll(12'h000, 1, 1, 1);
    chk("R8 reti on empty", {28'b0, insvc}, 4'b0000);
    poll(12'h040, 1, 0, 0);
    chk("R5 no strobe no req", {31'b0, req}, 0);
    poll(12'h040, 1, 0, 1);
    chk("R7 resumed req", {31'b0, req}, 1);
    chk("R4 resumed idx", {28'b0, idx}, 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule